// File: doc/BRIEF.md
# Registered PROM with Initialize Word

This block is a 2048-word, 8-bit read-only memory with an edge-triggered output register. A read address is presented. On the next rising clock edge the addressed word is captured and driven. The address may then move on to the next location while the captured word stays on the outputs. Real three-state pins are replaced by an 8-bit data bus and a drive flag. While the flag is low the data bus reads zero.

Two configuration bytes sit just past the data array: a control byte and an initialize word. The control byte selects how the outputs are enabled. The first option is a level-sensitive enable that acts at once. The second is an enable that is sampled on each clock edge. An active-low initialize input forces the initialize word into the output register straight away, with no clock needed. A programming strobe can write the array and both configuration bytes. A reset input stands in for power-up. It clears the register state but leaves all programmed contents in place.

Top module: `pipe_prom`

## Requirements
- R1: Each rising clock edge with `rst` low and `init_n` high loads the word at `rd_addr` into the output register. The word stays on `dout` until the next rising edge, even if `rd_addr` changes in between.
- R2: A strobe (`prog_we` high at a rising edge) with `prog_addr` below 0x800 writes `prog_data` into the array. Address 0x800 writes the control byte and 0x801 writes the initialize word. The new value is in effect from that edge onward.
- R3: A control byte of exactly 0x01 selects the clocked enable mode. Any other value, including the power-up default of 0x00, selects the immediate enable mode.
- R4: In immediate mode, `dout_drive` equals the inverse of `async_en_n` at all times, without waiting for a clock edge.
- R5: In clocked mode, `sync_en_n` is sampled at each rising edge. A sampled 1 makes `dout_drive` low from that edge, and a sampled 0 makes it high from that edge. A change between edges has no effect.
- R6: While `dout_drive` is low, `dout` is 0x00. While it is high, `dout` shows the output register.
- R7: A low level on `init_n` loads the initialize word into the output register at once, with no clock edge. The register keeps that word through any rising edge while `init_n` stays low.
- R8: The initialize word resets to 0x00, so initialize then clears the register. After 0xFF has been written to the initialize word, initialize sets the register to all ones.
- R9: `rst` high clears the output register to 0x00 and sets the clocked-enable flip-flop to the disabled state. The array, control byte and initialize word keep their contents.
- R10: A strobe with `prog_addr` above 0x801 changes nothing: no array word, control byte or initialize word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Power-up stand-in, active high, asynchronous |
| rd_addr | input | 11 | Read address |
| async_en_n | input | 1 | Immediate enable, active low (used in immediate mode) |
| sync_en_n | input | 1 | Clocked enable, active low (used in clocked mode) |
| init_n | input | 1 | Asynchronous initialize, active low |
| prog_we | input | 1 | Programming strobe |
| prog_addr | input | 12 | Programming address, 0x000 to 0x801 valid |
| prog_data | input | 8 | Programming data |
| dout | output | 8 | Data, 0x00 while not driven |
| dout_drive | output | 1 | High while the outputs are driven |

## Verification
A stale or wrong output register shows on `dout` one edge after the address was applied, provided the drive flag is high. An initialize word stored in the wrong place, or never stored, shows up as soon as `init_n` goes low with the outputs enabled. A wrong enable mode or a wrong enable flip-flop makes `dout_drive` disagree with the enable inputs. In immediate mode this is visible at once. In clocked mode it is visible at the edge after the enable changes. A high-address strobe that aliases into the configuration bytes flips the enable mode or the initialize word, and the next enable toggle or initialize pulse exposes it.

// File: rtl/pipe_prom.sv
module pipe_prom #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  logic          async_en_n,
  input  logic          sync_en_n,
  input  logic          init_n,
  input  logic          prog_we,
  input  logic [AW:0]   prog_addr,
  input  logic [DW-1:0] prog_data,
  output logic [DW-1:0] dout,
  output logic          dout_drive
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CTRL_ADDR = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] INIT_ADDR = CTRL_ADDR + 1'b1;
  localparam logic [DW-1:0] SYNC_CODE = DW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ctrl_q = '0;
  logic [DW-1:0] init_q = '0;
  logic [DW-1:0] out_q;
  logic          off_q;
  logic [DW-1:0] rd_word;
  logic          sync_mode;

  assign rd_word   = mem[rd_addr];
  assign sync_mode = (ctrl_q == SYNC_CODE);

  always_ff @(posedge clk) begin
    if (prog_we && !prog_addr[AW]) mem[prog_addr[AW-1:0]] <= prog_data;
    if (prog_we && prog_addr == CTRL_ADDR) ctrl_q <= prog_data;
    if (prog_we && prog_addr == INIT_ADDR) init_q <= prog_data;
  end

  always_ff @(posedge clk or posedge rst or negedge init_n) begin
    if (rst)          out_q <= '0;
    else if (!init_n) out_q <= init_q;
    else              out_q <= rd_word;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) off_q <= 1'b1;
    else     off_q <= sync_en_n;
  end

  assign dout_drive = sync_mode ? !off_q : !async_en_n;
  assign dout       = dout_drive ? out_q : '0;
endmodule

module pipe_prom_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          init_n,
  input logic          sync_en_n,
  input logic          prog_we,
  input logic [AW:0]   prog_addr,
  input logic [DW-1:0] dout,
  input logic          dout_drive,
  input logic          sync_mode,
  input logic [DW-1:0] rd_word,
  input logic [DW-1:0] init_q,
  input logic [DW-1:0] ctrl_q
);
  localparam logic [AW:0] LAST_ADDR = {1'b1, {AW{1'b0}}} + 1'b1;

  p_read_word_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(init_n) && init_n && dout_drive) |-> dout == $past(rd_word));

  p_sync_enable_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sync_mode && $past(sync_mode)) |-> dout_drive == !$past(sync_en_n));

  p_init_word_r7: assert property (@(posedge clk) disable iff (rst)
    (!init_n && dout_drive) |-> dout == init_q);

  p_high_addr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (prog_we && prog_addr > LAST_ADDR) |=> ($stable(ctrl_q) && $stable(init_q)));
endmodule

bind pipe_prom pipe_prom_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .init_n(init_n), .sync_en_n(sync_en_n),
  .prog_we(prog_we), .prog_addr(prog_addr), .dout(dout),
  .dout_drive(dout_drive), .sync_mode(sync_mode), .rd_word(rd_word),
  .init_q(init_q), .ctrl_q(ctrl_q)
);

// File: tb/pipe_prom_tb.sv
module pipe_prom_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [10:0] rd_addr = '0;
  logic        async_en_n = 1;
  logic        sync_en_n = 0;
  logic        init_n = 1;
  logic        prog_we = 0;
  logic [11:0] prog_addr = '0;
  logic [7:0]  prog_data = '0;
  logic [7:0]  dout;
  logic        dout_drive;
  int checks = 0;
  int errors = 0;

  pipe_prom dut_i (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .async_en_n(async_en_n),
    .sync_en_n(sync_en_n), .init_n(init_n), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data), .dout(dout),
    .dout_drive(dout_drive)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic prog(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    prog_we = 1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic rd(input string req, input logic [10:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk); #1;
    chk(req, {dout_drive, dout}, {1'b1, exp});
  endtask

  task automatic t_reset;
    #1;
    chk("R9 reset, immediate mode disabled", {dout_drive, dout}, 9'h000);
    @(negedge clk); rst = 0;
    async_en_n = 0; #1;
    chk("R9 register cleared by reset", {dout_drive, dout}, 9'h100);
  endtask

  task automatic t_read;
    prog(12'h005, 8'hA5);
    prog(12'h7FF, 8'h3C);
    prog(12'h000, 8'h11);
    rd("R1 read 0x005", 11'h005, 8'hA5);
    rd("R1 read 0x7FF", 11'h7FF, 8'h3C);
    rd("R2 read 0x000", 11'h000, 8'h11);
    rd_addr = 11'h005; #2;
    chk("R1 output held after address change", {dout_drive, dout}, 9'h111);
  endtask

  task automatic t_async;
    @(negedge clk);
    async_en_n = 1; #1;
    chk("R4 off without clock", {dout_drive, dout}, 9'h000);
    async_en_n = 0; #1;
    chk("R4 on without clock", {dout_drive, dout}, 9'h111);
  endtask

  task automatic t_init_clear;
    @(negedge clk);
    init_n = 0; #1;
    chk("R8 unprogrammed init clears", {dout_drive, dout}, 9'h100);
    @(negedge clk); init_n = 1;
  endtask

  task automatic t_init_gate;
    prog(12'h801, 8'hC3);
    @(negedge clk);
    async_en_n = 1; init_n = 0; #1;
    chk("R6 init hidden while disabled", {dout_drive, dout}, 9'h000);
    async_en_n = 0; #1;
    chk("R7 init word loaded", {dout_drive, dout}, 9'h1C3);
    @(posedge clk); #1;
    chk("R7 init held across edge", {dout_drive, dout}, 9'h1C3);
    @(negedge clk); init_n = 1;
    @(posedge clk); #1;
    chk("R1 read after init release", {dout_drive, dout}, 9'h1A5);
  endtask

  task automatic t_sync;
    prog(12'h800, 8'h01);
    async_en_n = 1; #1;
    chk("R3 clocked mode ignores immediate enable", {dout_drive, dout}, 9'h1A5);
    @(negedge clk); sync_en_n = 1; #1;
    chk("R5 no change before edge", {dout_drive, dout}, 9'h1A5);
    @(posedge clk); #1;
    chk("R5 off from edge", {dout_drive, dout}, 9'h000);
    @(negedge clk); sync_en_n = 0; #1;
    chk("R5 still off before edge", {dout_drive, dout}, 9'h000);
    @(posedge clk); #1;
    chk("R5 on from edge", {dout_drive, dout}, 9'h1A5);
  endtask

  task automatic t_ignore;
    prog(12'hC00, 8'h00);
    prog(12'hC01, 8'h55);
    prog(12'hFFF, 8'h77);
    prog(12'h805, 8'h99);
    @(negedge clk); sync_en_n = 1;
    @(posedge clk); #1;
    chk("R10 control byte unchanged", {dout_drive, dout}, 9'h000);
    @(negedge clk); sync_en_n = 0;
    rd("R10 array word 0x005 unchanged", 11'h005, 8'hA5);
    @(negedge clk); init_n = 0; #1;
    chk("R10 init word unchanged", {dout_drive, dout}, 9'h1C3);
    @(negedge clk); init_n = 1;
  endtask

  task automatic t_preset;
    prog(12'h801, 8'hFF);
    @(negedge clk); init_n = 0; #1;
    chk("R8 programmed init presets", {dout_drive, dout}, 9'h1FF);
    @(negedge clk); init_n = 1;
  endtask

  task automatic t_reset_keep;
    @(negedge clk); rst = 1; #1;
    chk("R9 clocked enable set by reset", {dout_drive, dout}, 9'h000);
    @(negedge clk); rst = 0; #1;
    chk("R9 still disabled before edge", {dout_drive, dout}, 9'h000);
    rd("R9 array kept through reset", 11'h7FF, 8'h3C);
    prog(12'h800, 8'h02);
    async_en_n = 0; #1;
    chk("R3 other control value is immediate mode", {dout_drive, dout}, 9'h13C);
    @(negedge clk); rst = 1; #1;
    chk("R9 register cleared, immediate mode", {dout_drive, dout}, 9'h100);
    @(negedge clk); rst = 0;
    rd("R9 array kept after second reset", 11'h005, 8'hA5);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    t_read;
    t_async;
    t_init_clear;
    t_init_gate;
    t_sync;
    t_ignore;
    t_preset;
    t_reset_keep;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule